// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the timing skeleton for a TFT raster panel: a pixel-rate enable derived from the reference clock, a divided pixel clock, horizontal and vertical sync, a data-enable window, the active pixel and line coordinates, and a one-cycle end-of-frame pulse. Downstream logic uses the coordinates and data-enable to fetch and present pixel data. Software programs the timing through a small write-only port that holds one control word and three timing words.

Each timing field is stored in a packed, biased form. Horizontal sync, back porch and front porch are counts minus one, split between two words. The active width is stored in units of 16 pixels. The vertical porches are stored as plain counts, while the vertical sync width is biased. The block decodes these fields into plain counts. It copies them into a working set only while it is stopped or at a frame boundary, so a frame never mixes two sets of timing.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every output is low: pix_ce, pclk_o, hsync_o, vsync_o, de_o, frame_done, pix_x and line_y.
- R2: The divisor sits in control word (address 0) bits 15:8. pix_ce pulses once every D reference cycles, where D is the divisor, and a divisor of 0 or 1 acts as 2. The unconverted pixel clock is low for the first floor(D/2) cycles of each pixel and high for the rest, so it is high in the pix_ce cycle.
- R3: Every line runs sync, then back porch, then active pixels, then front porch. In timing word 0 (address 1), back porch-1 has its low 8 bits at 31:24, front porch-1 has its low 8 bits at 23:16, and sync-1 has its low 6 bits at 15:10. In timing word 2 (address 3), back porch-1 bits 9:8 sit at 5:4, front porch-1 bits 9:8 at 1:0, and sync-1 bits 9:6 at 30:27.
- R4: The active width is a multiple of 16, and (width-1)>>4 is stored with its low 6 bits at word 0 bits 9:4 and its bit 6 at word 0 bit 3.
- R5: Frames run vertical sync lines, then back-porch lines, then active lines, then front-porch lines. In timing word 1 (address 2), the vertical back porch is stored unbiased at 31:24, the vertical front porch unbiased at 23:16 (either may be 0), sync-1 at 15:10, and height-1 bits 9:0 at 9:0. Height-1 bit 10 sits at word 2 bit 26.
- R6: de_o is high only on active pixels of active lines. pix_x and line_y then give the zero-based active column and row, and both are 0 whenever de_o is low.
- R7: Word 2 bit 21 inverts hsync_o, bit 20 inverts vsync_o and bit 22 inverts pclk_o. The inversions also apply while the generator is stopped.
- R8: When word 2 bits 25 and 24 are both set, hsync_o and vsync_o change on the rising pixel-clock edge, floor(D/2) cycles after the pixel starts. Otherwise they change at the start of each pixel.
- R9: frame_done is high for exactly one cycle: the pix_ce cycle of the last pixel of the last line of a frame, which is the last front-porch line when that porch is not zero.
- R10: Control bit 0 runs the generator. While it is clear there are no pix_ce, de_o or frame_done pulses and both syncs sit at their inactive level. Setting it again starts from the first pixel of the frame.
- R11: A timing word written while the generator runs takes effect only from the next frame start, and the frame in progress finishes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1..3 timing words |
| wr_data | input | 32 | Register write data |
| pix_ce | output | 1 | One-cycle enable on the last reference cycle of each pixel |
| pclk_o | output | 1 | Divided pixel clock, polarity selectable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable for active pixels |
| pix_x | output | 11 | Active column index |
| line_y | output | 11 | Active row index |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
A horizontal counter that skips or repeats a value shifts every later sync and data-enable edge on that line. The next line start then lands in the wrong pixel, so the pixel-by-pixel comparison fails within one line. A corrupted vertical counter or a working copy loaded at the wrong time shows up as a wrong line_y, a wrong vsync_o or a misplaced frame_done. This appears by the next line boundary or, for a mid-frame write, in the first pixel whose timing differs between the old and new values. A divider fault moves pix_ce away from the expected period on the very next pixel.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int REG_W    = 32;
  localparam int REG_N    = 4;
  localparam int ADDR_W   = $clog2(REG_N);
  localparam int DIV_W    = 8;
  localparam int HSEG_W   = 11;
  localparam int VSW_W    = 7;
  localparam int VPORCH_W = 8;
  localparam int ACT_W    = 12;
  localparam int HCNT_W   = ACT_W + 1;
  localparam int VCNT_W   = ACT_W;
  localparam int COORD_W  = ACT_W - 1;

  typedef struct packed {
    logic [DIV_W-1:0]    div;
    logic [HSEG_W-1:0]   hsw;
    logic [HSEG_W-1:0]   hbp;
    logic [HSEG_W-1:0]   hfp;
    logic [ACT_W-1:0]    hact;
    logic [VSW_W-1:0]    vsw;
    logic [VPORCH_W-1:0] vbp;
    logic [VPORCH_W-1:0] vfp;
    logic [ACT_W-1:0]    vact;
    logic                inv_h;
    logic                inv_v;
    logic                inv_p;
    logic                sync_on_rise;
  } timing_t;

  // Unpack the biased, split register fields into plain counts.
  function automatic timing_t decode_timing(input logic [REG_W-1:0] ctl,
                                            input logic [REG_W-1:0] w0,
                                            input logic [REG_W-1:0] w1,
                                            input logic [REG_W-1:0] w2);
    timing_t    t;
    logic [7:0] blocks;
    t.div   = (ctl[15:8] < 8'd2) ? 8'd2 : ctl[15:8];
    t.hbp   = {1'b0, w2[5:4], w0[31:24]} + 11'd1;
    t.hfp   = {1'b0, w2[1:0], w0[23:16]} + 11'd1;
    t.hsw   = {1'b0, w2[30:27], w0[15:10]} + 11'd1;
    blocks  = {1'b0, w0[3], w0[9:4]} + 8'd1;
    t.hact  = {blocks, 4'b0000};
    t.vbp   = w1[31:24];
    t.vfp   = w1[23:16];
    t.vsw   = {1'b0, w1[15:10]} + 7'd1;
    t.vact  = {1'b0, w2[26], w1[9:0]} + 12'd1;
    t.inv_h = w2[21];
    t.inv_v = w2[20];
    t.inv_p = w2[22];
    t.sync_on_rise = w2[25] & w2[24];
    return t;
  endfunction

  function automatic logic [HCNT_W-1:0] h_total(input timing_t t);
    return HCNT_W'(t.hsw) + HCNT_W'(t.hbp) + HCNT_W'(t.hfp) + HCNT_W'(t.hact);
  endfunction

  function automatic logic [VCNT_W-1:0] v_total(input timing_t t);
    return VCNT_W'(t.vsw) + VCNT_W'(t.vbp) + VCNT_W'(t.vfp) + t.vact;
  endfunction
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              load_shadow,
  output logic              en,
  output timing_t           tm_act
);
  logic [REG_W-1:0] regs [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(i)))
        regs[i] <= wr_data;
    end
  end

  assign en = regs[0][0];

  // Working copy: follows the registers while stopped, else only at frame wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tm_act <= decode_timing('0, '0, '0, '0);
    else if (load_shadow)
      tm_act <= decode_timing(regs[0], regs[1], regs[2], regs[3]);
  end
endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             pclk_hi,
  output logic             rise_strobe
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half = div >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + DIV_W'(1);
  end

  assign tick        = run && (cnt == div - DIV_W'(1));
  assign pclk_hi     = run && (cnt >= half);
  assign rise_strobe = run && (cnt == half - DIV_W'(1));
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
  import lcdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  timing_t            tm,
  output logic [HCNT_W-1:0]  hc,
  output logic [VCNT_W-1:0]  vc,
  output logic [HCNT_W-1:0]  h_tot,
  output logic               hs_act,
  output logic               vs_act,
  output logic               de,
  output logic               frame_end,
  output logic [COORD_W-1:0] px,
  output logic [COORD_W-1:0] ln
);
  logic [VCNT_W-1:0] v_tot;
  logic [HCNT_W-1:0] h0;
  logic [VCNT_W-1:0] v0;
  logic              h_last, v_last, h_in, v_in;

  assign h_tot  = h_total(tm);
  assign v_tot  = v_total(tm);
  assign h0     = HCNT_W'(tm.hsw) + HCNT_W'(tm.hbp);
  assign v0     = VCNT_W'(tm.vsw) + VCNT_W'(tm.vbp);
  assign h_last = (hc == h_tot - HCNT_W'(1));
  assign v_last = (vc == v_tot - VCNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (!run) begin
      hc <= '0;
      vc <= '0;
    end else if (tick) begin
      if (h_last) begin
        hc <= '0;
        vc <= v_last ? '0 : vc + VCNT_W'(1);
      end else begin
        hc <= hc + HCNT_W'(1);
      end
    end
  end

  assign h_in      = (hc >= h0) && (hc < h0 + HCNT_W'(tm.hact));
  assign v_in      = (vc >= v0) && (vc < v0 + tm.vact);
  assign hs_act    = run && (hc < HCNT_W'(tm.hsw));
  assign vs_act    = run && (vc < VCNT_W'(tm.vsw));
  assign de        = run && h_in && v_in;
  assign frame_end = h_last && v_last;
  assign px        = de ? COORD_W'(hc - h0) : '0;
  assign ln        = de ? COORD_W'(vc - v0) : '0;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import lcdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic               pix_ce,
  output logic               pclk_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] line_y,
  output logic               frame_done
);
  timing_t           tm_act;
  logic              run, tick, pclk_hi, rise_strobe;
  logic              load_shadow, frame_end;
  logic              hs_act, vs_act, hs_q, vs_q, hs_sel, vs_sel;
  logic [HCNT_W-1:0] hc, h_tot;
  logic [VCNT_W-1:0] vc;

  assign load_shadow = !run || (tick && frame_end);

  lcdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_shadow(load_shadow), .en(run), .tm_act(tm_act)
  );

  lcdt_pixdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(tm_act.div),
    .tick(tick), .pclk_hi(pclk_hi), .rise_strobe(rise_strobe)
  );

  lcdt_scan u_scan (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .tm(tm_act),
    .hc(hc), .vc(vc), .h_tot(h_tot), .hs_act(hs_act), .vs_act(vs_act),
    .de(de_o), .frame_end(frame_end), .px(pix_x), .ln(line_y)
  );

  // Syncs retimed to the rising pixel-clock edge when that option is on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else if (!run) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else if (rise_strobe) begin
      hs_q <= hs_act;
      vs_q <= vs_act;
    end
  end

  assign hs_sel     = tm_act.sync_on_rise ? hs_q : hs_act;
  assign vs_sel     = tm_act.sync_on_rise ? vs_q : vs_act;
  assign hsync_o    = hs_sel ^ tm_act.inv_h;
  assign vsync_o    = vs_sel ^ tm_act.inv_v;
  assign pclk_o     = pclk_hi ^ tm_act.inv_p;
  assign pix_ce     = tick;
  assign frame_done = tick && frame_end;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import lcdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              pix_ce,
  input logic              de_o,
  input logic              frame_done,
  input logic              frame_end,
  input logic              hs_act,
  input logic              vs_act,
  input logic [HCNT_W-1:0] hc,
  input logic [HCNT_W-1:0] h_tot,
  input logic [VCNT_W-1:0] vc,
  input timing_t           tm_act
);
  AST_CE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce); // R2
  AST_HC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc < h_tot)); // R3
  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (!hs_act && !vs_act)); // R6
  AST_FD_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> pix_ce); // R9
  AST_FD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pix_ce && !de_o && !frame_done)); // R10
  AST_START_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (hc == '0 && vc == '0)); // R10
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(pix_ce && frame_end)) |-> $stable(tm_act)); // R11
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pix_ce(pix_ce), .de_o(de_o),
  .frame_done(frame_done), .frame_end(frame_end), .hs_act(hs_act),
  .vs_act(vs_act), .hc(hc), .h_tot(h_tot), .vc(vc), .tm_act(tm_act)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_ce, pclk_o, hsync_o, vsync_o, de_o, frame_done;
  logic [10:0] pix_x, line_y;

  always #5 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_ce(pix_ce), .pclk_o(pclk_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .pix_x(pix_x), .line_y(line_y),
    .frame_done(frame_done)
  );

  typedef struct {
    int w, h, hsw, hbp, hfp, vsw, vbp, vfp, div;
    bit ih, iv, ip, sc, sr;
  } cfg_t;

  typedef struct {
    bit hs, vs, de, fd;
    int x, y;
  } item_t;

  item_t expq[$];
  int  n_vec = 0, n_bad = 0;
  int  exp_div = 2;
  bit  exp_ip = 0, exp_rise = 0, tb_en = 0, done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic cfg_t base_cfg();
    cfg_t c;
    c.w = 16; c.h = 3; c.hsw = 2; c.hbp = 3; c.hfp = 2;
    c.vsw = 1; c.vbp = 1; c.vfp = 1; c.div = 2;
    c.ih = 0; c.iv = 0; c.ip = 0; c.sc = 0; c.sr = 0;
    return c;
  endfunction

  function automatic logic [31:0] word0(input cfg_t c);
    int v = (((c.hbp - 1) & 255) << 24) | (((c.hfp - 1) & 255) << 16) |
            (((c.hsw - 1) & 63) << 10) | ((((c.w - 1) >> 4) & 63) << 4) |
            ((((c.w - 1) >> 10) & 1) << 3);
    return 32'(v);
  endfunction

  function automatic logic [31:0] word1(input cfg_t c);
    int v = (c.vbp << 24) | (c.vfp << 16) | (((c.vsw - 1) & 63) << 10) |
            ((c.h - 1) & 1023);
    return 32'(v);
  endfunction

  function automatic logic [31:0] word2(input cfg_t c);
    int v = ((((c.hsw - 1) >> 6) & 15) << 27) | ((((c.h - 1) >> 10) & 1) << 26) |
            (int'(c.sc) << 25) | (int'(c.sr) << 24) | (int'(c.ip) << 22) |
            (int'(c.ih) << 21) | (int'(c.iv) << 20) |
            ((((c.hbp - 1) >> 8) & 3) << 4) | (((c.hfp - 1) >> 8) & 3);
    return 32'(v);
  endfunction

  function automatic logic [31:0] ctlw(input cfg_t c, input bit en);
    return 32'((c.div & 255) << 8) | 32'(en);
  endfunction

  // Register write starting now; caller stays clear of the rising edge.
  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a == 0) tb_en = d[0];
  endtask

  task automatic configure(input cfg_t c);
    wr(1, word0(c)); wr(2, word1(c)); wr(3, word2(c)); wr(0, ctlw(c, 0));
    exp_div  = (c.div < 2) ? 2 : c.div;
    exp_ip   = c.ip;
    exp_rise = c.sc && c.sr;
  endtask

  task automatic push_frame(input cfg_t c, input int limit);
    int ht = c.hsw + c.hbp + c.w + c.hfp;
    int vt = c.vsw + c.vbp + c.h + c.vfp;
    int n = 0;
    for (int v = 0; v < vt; v++) begin
      for (int h = 0; h < ht; h++) begin
        item_t it;
        bit ah, av;
        if (limit >= 0 && n >= limit) return;
        ah = (h >= c.hsw + c.hbp) && (h < c.hsw + c.hbp + c.w);
        av = (v >= c.vsw + c.vbp) && (v < c.vsw + c.vbp + c.h);
        it.de = ah && av;
        it.x  = it.de ? h - (c.hsw + c.hbp) : 0;
        it.y  = it.de ? v - (c.vsw + c.vbp) : 0;
        it.hs = (h < c.hsw) ^ c.ih;
        it.vs = (v < c.vsw) ^ c.iv;
        it.fd = (v == vt - 1) && (h == ht - 1);
        expq.push_back(it);
        n++;
      end
    end
  endtask

  task automatic wait_below(input int lvl);
    do begin @(posedge clk); #1; end while (expq.size() > lvl);
  endtask

  task automatic run_and_stop(input cfg_t c);
    wr(0, ctlw(c, 1));
    wait_below(0);
    wr(0, ctlw(c, 0));
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Monitor: pops one expected pixel per pix_ce and compares the ports.
  initial begin : mon
    item_t cur;
    bit post = 0;
    int cyc = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (post) begin
          post = 0;
          if (expq.size() > 0) begin
            chk("R8 hsync at pixel start", int'(hsync_o), int'(exp_rise ? cur.hs : expq[0].hs));
            chk("R8 vsync at pixel start", int'(vsync_o), int'(exp_rise ? cur.vs : expq[0].vs));
            chk("R2 pclk low phase", int'(pclk_o), int'(exp_ip));
          end
        end
        if (tb_en) cyc++; else cyc = 0;
        if (pix_ce) begin
          if (expq.size() == 0) begin
            chk("R10 pixel with nothing expected", 1, 0);
          end else begin
            cur = expq.pop_front();
            chk("R2 pixel period", cyc, exp_div);
            chk("R2 pclk high phase", int'(pclk_o), int'(!exp_ip));
            chk("R3 hsync", int'(hsync_o), int'(cur.hs));
            chk("R5 vsync", int'(vsync_o), int'(cur.vs));
            chk("R6 de", int'(de_o), int'(cur.de));
            chk("R4 R6 pix_x", int'(pix_x), cur.x);
            chk("R5 R6 line_y", int'(line_y), cur.y);
            chk("R9 frame_done", int'(frame_done), int'(cur.fd));
            post = 1;
          end
          cyc = 0;
        end else if (frame_done) begin
          chk("R9 frame_done without pixel", 1, 0);
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin : drive
    cfg_t a, b, c, d, e, f, g;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pix_ce", int'(pix_ce), 0);
    chk("R1 pclk_o", int'(pclk_o), 0);
    chk("R1 hsync_o", int'(hsync_o), 0);
    chk("R1 vsync_o", int'(vsync_o), 0);
    chk("R1 de_o", int'(de_o), 0);
    chk("R1 frame_done", int'(frame_done), 0);
    chk("R1 pix_x", int'(pix_x), 0);
    chk("R1 line_y", int'(line_y), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Base timing, two frames back to back (R3 R5 R6 R9)
    a = base_cfg();
    configure(a);
    push_frame(a, -1); push_frame(a, -1);
    run_and_stop(a);

    // Odd divisor, zero vertical porches, edge bit without control bit (R2 R5 R8)
    b = base_cfg();
    b.w = 32; b.h = 2; b.hsw = 1; b.hbp = 1; b.hfp = 1;
    b.vsw = 2; b.vbp = 0; b.vfp = 0; b.div = 5; b.sr = 1;
    configure(b);
    push_frame(b, -1);
    run_and_stop(b);

    // Divisor below legal range acts as 2 (R2)
    c = base_cfg(); c.div = 1;
    configure(c);
    push_frame(c, -1);
    run_and_stop(c);

    // Inversions plus rising-edge sync (R7 R8)
    d = base_cfg(); d.div = 4; d.ih = 1; d.iv = 1; d.ip = 1; d.sc = 1; d.sr = 1;
    configure(d);
    push_frame(d, -1);
    run_and_stop(d);
    chk("R7 R10 idle hsync inverted", int'(hsync_o), 1);
    chk("R7 R10 idle vsync inverted", int'(vsync_o), 1);
    chk("R7 idle pclk inverted", int'(pclk_o), 1);
    chk("R10 idle de", int'(de_o), 0);
    chk("R10 idle pix_ce", int'(pix_ce), 0);

    // Mid-frame timing write waits for the frame boundary (R11)
    e = base_cfg(); e.hfp = 5; e.hsw = 3; e.hbp = 2;
    configure(a);
    push_frame(a, -1);
    push_frame(e, -1);
    wr(0, ctlw(a, 1));
    wait_below(138 + 100);
    wr(1, word0(e)); wr(3, word2(e));
    wait_below(0);
    wr(0, ctlw(a, 0));
    repeat (3) @(posedge clk);
    #1;

    // Stop mid-frame, then restart from the top (R10)
    configure(a);
    push_frame(a, 40);
    run_and_stop(a);
    push_frame(a, -1);
    run_and_stop(a);

    // Upper split bits of horizontal fields and width MSB (R3 R4)
    f = base_cfg();
    f.w = 1040; f.h = 2; f.hsw = 70; f.hbp = 300; f.hfp = 260;
    f.vsw = 1; f.vbp = 0; f.vfp = 0;
    configure(f);
    push_frame(f, -1);
    run_and_stop(f);

    // Height above 1024 lines uses the extra height bit (R5)
    g = base_cfg();
    g.w = 16; g.h = 1025; g.hsw = 1; g.hbp = 1; g.hfp = 1;
    g.vsw = 1; g.vbp = 0; g.vfp = 0;
    configure(g);
    push_frame(g, -1);
    run_and_stop(g);

    chk("R10 queue drained", expq.size(), 0);
    done = 1;
    summary();
  end
endmodule